// File: doc/BRIEF.md
# Vectored Interrupt Control Logic

This block sits beside a small processor core and decides, once per instruction boundary, whether an interrupt is taken and where execution continues. It watches one non-maskable input, three maskable vectored inputs and one general request line. The maskable inputs pass only when the global enable is set and their own mask bit is clear. The non-maskable input passes regardless. Every accepted interrupt clears the global enable, so nesting needs another enable instruction. The core owns stacking of the program counter.

Each vectored input has a fixed service-routine address. The general request has no address of its own. When it is accepted, the block drives an acknowledge strobe for a fixed number of cycles. On the last cycle of that strobe it captures the byte that external hardware places on the data bus. A restart opcode of the form 11nnn111 is turned into the address nnn × 8.

The core reports an instruction boundary on `insn_end_i`. The block answers with a one-cycle `taken_o` pulse that carries the target address on `vector_o`.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `taken_o` and `inta_o` are low and `ack_byte_o` is 0x00. The global enable is off. All three mask bits are set, so a maskable request is not taken after an enable until the mask is rewritten.
- R2: A request on `nmi_i` at a boundary is taken with vector 0x0024, whatever the global enable and mask state.
- R3: With the global enable set and the mask bit clear, `lvl7_i`, `lvl6_i` and `lvl5_i` are taken with vectors 0x003C, 0x0034 and 0x002C. Mask bit 2 gates `lvl7_i`, bit 1 gates `lvl6_i` and bit 0 gates `lvl5_i`. A 1 masks the input.
- R4: A maskable request whose mask bit is 1, or any maskable request while the global enable is off, produces no `taken_o`.
- R5: When several requests are present at one boundary, exactly one is taken. The order from highest to lowest is `nmi_i`, `lvl7_i`, `lvl6_i`, `lvl5_i`, `gen_req_i`.
- R6: `gen_req_i` is accepted only while the global enable is set. When accepted, `inta_o` rises in the cycle after the boundary and stays high for INTA_CYCLES cycles (default 2). `inta_o` and `taken_o` are never high together.
- R7: The block samples `data_i` on the last `inta_o` cycle. The byte appears on `ack_byte_o`, and `taken_o` pulses in the cycle after `inta_o` falls. A byte 11nnn111 gives vector nnn × 8, so 0xE7 gives 0x0020 and 0xFF gives 0x0038. Any other byte gives vector 0x0000.
- R8: Accepting any interrupt clears the global enable. `ei_i` sets it and `di_i` clears it, and `di_i` wins when both are high in the same cycle.
- R9: A request is evaluated only when `insn_end_i` is high, no acknowledge strobe is running and `taken_o` is low. `taken_o` is a single-cycle pulse, and the vector for a vectored input appears in the cycle after the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request |
| lvl7_i | input | 1 | Highest maskable vectored request |
| lvl6_i | input | 1 | Middle maskable vectored request |
| lvl5_i | input | 1 | Lowest maskable vectored request |
| gen_req_i | input | 1 | General request, target supplied externally |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| mask_we_i | input | 1 | Write the mask register |
| mask_wdata_i | input | 3 | New mask bits, 1 = masked |
| insn_end_i | input | 1 | Core is at an instruction boundary |
| data_i | input | 8 | External data bus during acknowledge |
| taken_o | output | 1 | Interrupt-taken pulse |
| vector_o | output | 16 | Service-routine address |
| inta_o | output | 1 | Acknowledge strobe |
| ack_byte_o | output | 8 | Byte captured during acknowledge |

## Verification
Each vectored input is raised alone under three conditions: enable set with its mask bit clear, enable off, and mask bit set. Together these separate the vector table from the two gating terms. All inputs are then raised at once and removed one at a time from the top, which exposes any wrong position in the priority chain. The general request is driven with 0xE7, 0xFF and a non-restart byte, which tells the opcode decode apart from the strobe timing. A boundary held high under a steady request, plus an enable and disable in the same cycle, cover the one-pulse rule and the disable priority.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC = 5;
  localparam int SRC_NMI = 0;
  localparam int SRC_L7  = 1;
  localparam int SRC_L6  = 2;
  localparam int SRC_L5  = 3;
  localparam int SRC_GEN = 4;

  function automatic logic [15:0] fixed_vec(input logic [NSRC-1:0] grant);
    logic [15:0] v;
    v = 16'h0000;
    if (grant[SRC_NMI]) v = 16'h0024;
    if (grant[SRC_L7])  v = 16'h003C;
    if (grant[SRC_L6])  v = 16'h0034;
    if (grant[SRC_L5])  v = 16'h002C;
    return v;
  endfunction

  function automatic logic [15:0] restart_vec(input logic [7:0] op);
    if (op[7:6] == 2'b11 && op[2:0] == 3'b111)
      return {10'd0, op[5:3], 3'b000};
    return 16'h0000;
  endfunction
endpackage

// File: rtl/vic_enable.sv
module vic_enable #(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              accept_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  output logic              gie_o,
  output logic [MASK_W-1:0] mask_o
);
  logic              gie_q, gie_d;
  logic [MASK_W-1:0] mask_q, mask_d;

  always_comb begin
    gie_d = gie_q;
    if (ei_i) gie_d = 1'b1;
    if (di_i || accept_i) gie_d = 1'b0;
    mask_d = mask_we_i ? mask_wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      gie_q  <= gie_d;
      mask_q <= mask_d;
    end
  end

  assign gie_o  = gie_q;
  assign mask_o = mask_q;

  p_accept_clears_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !gie_o);
  p_di_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    di_i |=> !gie_o);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_i,
  input  logic            lvl7_i,
  input  logic            lvl6_i,
  input  logic            lvl5_i,
  input  logic            gen_i,
  input  logic            gie_i,
  input  logic [2:0]      mask_i,
  output logic [NSRC-1:0] grant_o
);
  logic [NSRC-1:0] req;

  always_comb begin
    req          = '0;
    req[SRC_NMI] = nmi_i;
    req[SRC_L7]  = lvl7_i & gie_i & ~mask_i[2];
    req[SRC_L6]  = lvl6_i & gie_i & ~mask_i[1];
    req[SRC_L5]  = lvl5_i & gie_i & ~mask_i[0];
    req[SRC_GEN] = gen_i  & gie_i;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_prio
    if (i == 0) begin : g_top
      assign grant_o[i] = req[i];
    end else begin : g_rest
      assign grant_o[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_masked_l7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[SRC_L7] |-> (gie_i && !mask_i[2] && lvl7_i));
  p_gen_needs_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[SRC_GEN] |-> gie_i);
endmodule

// File: rtl/vic_ack.sv
module vic_ack
  import vic_pkg::*;
#(
  parameter int INTA_CYCLES = 2,
  parameter int VEC_W = 16,
  parameter int BYTE_W = 8,
  localparam int CNT_W = (INTA_CYCLES > 1) ? $clog2(INTA_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vec_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              start_gen_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              busy_o,
  output logic              taken_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              inta_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTA_CYCLES - 1);

  logic              ack_q, ack_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              taken_q, taken_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [BYTE_W-1:0] byte_q, byte_d;

  always_comb begin
    ack_d   = ack_q;
    cnt_d   = cnt_q;
    taken_d = 1'b0;
    vec_d   = vec_q;
    byte_d  = byte_q;
    if (ack_q) begin
      if (cnt_q == LAST) begin
        ack_d   = 1'b0;
        byte_d  = data_i;
        vec_d   = restart_vec(data_i);
        taken_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start_vec_i) begin
      taken_d = 1'b1;
      vec_d   = vec_i;
    end else if (start_gen_i) begin
      ack_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      cnt_q   <= '0;
      taken_q <= 1'b0;
      vec_q   <= '0;
      byte_q  <= '0;
    end else begin
      ack_q   <= ack_d;
      cnt_q   <= cnt_d;
      taken_q <= taken_d;
      vec_q   <= vec_d;
      byte_q  <= byte_d;
    end
  end

  assign busy_o   = ack_q;
  assign inta_o   = ack_q;
  assign taken_o  = taken_q;
  assign vector_o = vec_q;
  assign byte_o   = byte_q;

  p_taken_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |=> !taken_o);
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(inta_o && taken_o));
  p_fall_gives_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inta_o) |-> taken_o);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int INTA_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_i,
  input  logic        lvl7_i,
  input  logic        lvl6_i,
  input  logic        lvl5_i,
  input  logic        gen_req_i,
  input  logic        ei_i,
  input  logic        di_i,
  input  logic        mask_we_i,
  input  logic [2:0]  mask_wdata_i,
  input  logic        insn_end_i,
  input  logic [7:0]  data_i,
  output logic        taken_o,
  output logic [15:0] vector_o,
  output logic        inta_o,
  output logic [7:0]  ack_byte_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_n_int;
  logic            gie;
  logic [2:0]      mask;
  logic [NSRC-1:0] grant;
  logic            busy;
  logic            window;
  logic            accept;
  logic            start_vec;
  logic            start_gen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign window    = insn_end_i & ~busy & ~taken_o;
  assign accept    = window & (|grant);
  assign start_gen = window & grant[SRC_GEN];
  assign start_vec = accept & ~grant[SRC_GEN];

  vic_enable #(.MASK_W(3)) u_enable (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .accept_i     (accept),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .gie_o        (gie),
    .mask_o       (mask)
  );

  vic_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .nmi_i   (nmi_i),
    .lvl7_i  (lvl7_i),
    .lvl6_i  (lvl6_i),
    .lvl5_i  (lvl5_i),
    .gen_i   (gen_req_i),
    .gie_i   (gie),
    .mask_i  (mask),
    .grant_o (grant)
  );

  vic_ack #(.INTA_CYCLES(INTA_CYCLES), .VEC_W(16), .BYTE_W(8)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_vec_i (start_vec),
    .vec_i       (fixed_vec(grant)),
    .start_gen_i (start_gen),
    .data_i      (data_i),
    .busy_o      (busy),
    .taken_o     (taken_o),
    .vector_o    (vector_o),
    .inta_o      (inta_o),
    .byte_o      (ack_byte_o)
  );

  p_nmi_vector_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (window && nmi_i) |=> (taken_o && vector_o == 16'h0024));
  p_boundary_only_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!insn_end_i && !busy) |=> !taken_o);
endmodule

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_i = 0, lvl7_i = 0, lvl6_i = 0, lvl5_i = 0, gen_req_i = 0;
  logic        ei_i = 0, di_i = 0, mask_we_i = 0, insn_end_i = 0;
  logic [2:0]  mask_wdata_i = 3'b111;
  logic [7:0]  data_i = 8'h00;
  logic        taken_o, inta_o;
  logic [15:0] vector_o;
  logic [7:0]  ack_byte_o;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .lvl7_i(lvl7_i), .lvl6_i(lvl6_i),
    .lvl5_i(lvl5_i), .gen_req_i(gen_req_i), .ei_i(ei_i), .di_i(di_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .insn_end_i(insn_end_i),
    .data_i(data_i), .taken_o(taken_o), .vector_o(vector_o), .inta_o(inta_o),
    .ack_byte_o(ack_byte_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    nmi_i = 0; lvl7_i = 0; lvl6_i = 0; lvl5_i = 0; gen_req_i = 0;
  endtask

  task automatic pulse_ei();
    @(negedge clk) ei_i = 1;
    @(negedge clk) ei_i = 0;
  endtask

  task automatic write_mask(input logic [2:0] m);
    @(negedge clk) begin mask_we_i = 1; mask_wdata_i = m; end
    @(negedge clk) mask_we_i = 0;
  endtask

  // one boundary cycle, then check taken and vector on the following cycle
  task automatic attempt(input bit exp_taken, input logic [15:0] exp_vec, input string tag);
    @(negedge clk) insn_end_i = 1;
    @(negedge clk) begin
      insn_end_i = 0;
      chk({31'd0, taken_o}, {31'd0, exp_taken}, tag);
      if (exp_taken) chk({16'd0, vector_o}, {16'd0, exp_vec}, tag);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk({31'd0, taken_o}, 0, "R1 taken after reset");
    chk({31'd0, inta_o}, 0, "R1 inta after reset");
    chk({24'd0, ack_byte_o}, 0, "R1 byte after reset");
    pulse_ei();
    lvl7_i = 1; lvl6_i = 1; lvl5_i = 1;
    attempt(0, 16'h0, "R1 masks set at reset");
    clear_reqs();
    @(negedge clk) di_i = 1;
    @(negedge clk) di_i = 0;
  endtask

  task automatic t_nmi();
    nmi_i = 1;
    attempt(1, 16'h0024, "R2 nmi with enable off and masks set");
    clear_reqs();
  endtask

  task automatic t_vectored();
    write_mask(3'b000);
    pulse_ei(); lvl7_i = 1; attempt(1, 16'h003C, "R3 lvl7 vector");
    attempt(0, 16'h0, "R8 enable cleared by accept"); clear_reqs();
    pulse_ei(); lvl6_i = 1; attempt(1, 16'h0034, "R3 lvl6 vector"); clear_reqs();
    pulse_ei(); lvl5_i = 1; attempt(1, 16'h002C, "R3 lvl5 vector"); clear_reqs();
  endtask

  task automatic t_masking();
    lvl7_i = 1; attempt(0, 16'h0, "R4 lvl7 with enable off"); clear_reqs();
    write_mask(3'b010);
    pulse_ei(); lvl6_i = 1; attempt(0, 16'h0, "R4 lvl6 masked"); clear_reqs();
    lvl5_i = 1; attempt(1, 16'h002C, "R4 lvl5 still open"); clear_reqs();
    write_mask(3'b000);
  endtask

  task automatic t_priority();
    pulse_ei();
    nmi_i = 1; lvl7_i = 1; lvl6_i = 1; lvl5_i = 1; gen_req_i = 1;
    attempt(1, 16'h0024, "R5 nmi first");
    nmi_i = 0; pulse_ei(); attempt(1, 16'h003C, "R5 lvl7 second");
    lvl7_i = 0; pulse_ei(); attempt(1, 16'h0034, "R5 lvl6 third");
    lvl6_i = 0; pulse_ei(); attempt(1, 16'h002C, "R5 lvl5 fourth");
    clear_reqs();
  endtask

  task automatic run_gen(input logic [7:0] b, input logic [15:0] exp_vec, input string tag);
    pulse_ei();
    gen_req_i = 1;
    @(negedge clk) insn_end_i = 1;
    @(negedge clk) begin
      insn_end_i = 0; gen_req_i = 0;
      chk({31'd0, inta_o}, 1, {tag, " R6 inta first cycle"});
      chk({31'd0, taken_o}, 0, {tag, " R6 no taken during inta"});
      data_i = b;
    end
    @(negedge clk) chk({31'd0, inta_o}, 1, {tag, " R6 inta second cycle"});
    @(negedge clk) begin
      chk({31'd0, inta_o}, 0, {tag, " R6 inta ends"});
      chk({31'd0, taken_o}, 1, {tag, " R7 taken after inta"});
      chk({16'd0, vector_o}, {16'd0, exp_vec}, {tag, " R7 vector"});
      chk({24'd0, ack_byte_o}, {24'd0, b}, {tag, " R7 byte"});
      data_i = 8'h00;
    end
    @(negedge clk) chk({31'd0, taken_o}, 0, {tag, " R9 single pulse"});
  endtask

  task automatic t_gen();
    gen_req_i = 1;
    @(negedge clk) insn_end_i = 1;
    @(negedge clk) begin
      insn_end_i = 0;
      chk({31'd0, inta_o}, 0, "R6 gen ignored with enable off");
    end
    gen_req_i = 0;
    @(negedge clk);
    run_gen(8'hE7, 16'h0020, "R7 E7");
    run_gen(8'hFF, 16'h0038, "R7 FF");
    run_gen(8'h3E, 16'h0000, "R7 non-restart");
  endtask

  task automatic t_di_wins();
    @(negedge clk) begin ei_i = 1; di_i = 1; end
    @(negedge clk) begin ei_i = 0; di_i = 0; end
    lvl7_i = 1; attempt(0, 16'h0, "R8 di beats ei"); clear_reqs();
  endtask

  task automatic t_single();
    nmi_i = 1;
    @(negedge clk) insn_end_i = 1;
    @(negedge clk) chk({31'd0, taken_o}, 1, "R9 first boundary");
    @(negedge clk) chk({31'd0, taken_o}, 0, "R9 pulse ends with boundary held");
    @(negedge clk) insn_end_i = 0;
    @(negedge clk);
    @(negedge clk) chk({31'd0, taken_o}, 0, "R9 no boundary no taken");
    clear_reqs();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nmi();
    t_vectored();
    t_masking();
    t_priority();
    t_gen();
    t_di_wins();
    t_single();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule